// File: doc/BRIEF.md
# Single-Cycle Shift and Rotate Unit

This unit moves an 8-bit word left or right by any distance from 0 to 7 positions in one clock cycle. A 3-bit binary distance is decoded into a one-hot select. The select then picks one of eight precomputed candidate results, one for each distance. All variants share one datapath, and a mode input chooses what enters the vacated end of the word. The choices are:

- the bits that leave the other end (plain rotate);
- a constant 0;
- a constant 1;
- a copy of the sign bit;
- a nine-bit loop that passes through the carry flag.

The unit keeps a carry flag. The flag always takes the last bit pushed out of the word, and it is the ninth bit of the loop in rotate-through-carry mode. The result and the carry are captured together on a rising clock edge while the enable is high.

Top module: `srot_unit`

## Requirements
- R1: A synchronous reset, high at a rising edge, clears the result `q` and the carry `cy` to 0.
- R2: While `en` is low and reset is inactive, `q` and `cy` keep their values whatever the other inputs do.
- R3: The binary amount `amt` is decoded to a one-hot select. An amount of 0 loads `q` with `din` unchanged and leaves `cy` unchanged.
- R4: Mode 0 (rotate) moves the bits that leave one end back in at the other end. `dir`=0 rotates towards the MSB and `dir`=1 rotates towards the LSB.
- R5: Mode 1 shifts in the direction given by `dir` and fills the vacated positions with 0.
- R6: Mode 2 shifts in the direction given by `dir` and fills the vacated positions with 1.
- R7: Mode 3 is an arithmetic shift. With `dir`=1 every vacated upper position takes `din[7]`. With `dir`=0 the vacated lower positions take 0.
- R8: Mode 4 rotates the 9-bit value {cy, din} by `amt`, with `cy` as the bit above the MSB. The new `cy` is bit 8 of the rotated value.
- R9: In mode 0 an amount of 4 exchanges the upper and lower nibbles of `din`.
- R10: In modes 0 to 3 with a nonzero amount, `cy` takes the last bit pushed out of the word. That bit is `din[8-amt]` for `dir`=0 and `din[amt-1]` for `dir`=1.
- R11: Mode codes 5 to 7 load `q` with `din` and leave `cy` unchanged.
- R12: The result of an operation shows on `q` and `cy` after the rising edge at which `en` was high, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Capture enable for result and carry |
| din | input | 8 | Word to shift or rotate |
| amt | input | 3 | Binary distance, 0 to 7 |
| dir | input | 1 | 0 = towards MSB, 1 = towards LSB |
| mode | input | 3 | Fill source: 0 rotate, 1 zero, 2 one, 3 sign, 4 through carry |
| q | output | 8 | Registered result |
| cy | output | 1 | Registered carry flag |

## Verification
Every result is due exactly one rising edge after the edge at which its operands were applied with `en` high. The decode and select logic is combinational, and only the output registers lie in the path. The bench changes inputs on the falling edge, waits for one rising edge, and samples `q` and `cy` on the following falling edge. It also looks at `q` right after driving the inputs, before any edge, to confirm that nothing has passed through yet. The carry feeds the next operation, so the bench carries its own expected flag from one operation to the next across the whole sweep.

// File: rtl/srot_pkg.sv
package srot_pkg;
  typedef enum logic [2:0] {
    SR_ROT   = 3'd0,
    SR_FILL0 = 3'd1,
    SR_FILL1 = 3'd2,
    SR_SIGN  = 3'd3,
    SR_RCY   = 3'd4
  } sr_mode_e;

  localparam logic DIR_LEFT  = 1'b0;
  localparam logic DIR_RIGHT = 1'b1;

  // Codes above the carry loop are reserved and behave as a pass-through.
  function automatic logic mode_known(input logic [2:0] m);
    return m <= 3'd4;
  endfunction

  // The bit that enters the vacated end in a plain shift mode.
  function automatic logic fill_for(input logic [2:0] m, input logic dir, input logic msb);
    logic f;
    case (m)
      3'd2:    f = 1'b1;
      3'd3:    f = (dir == DIR_RIGHT) ? msb : 1'b0;
      default: f = 1'b0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/srot_decode.sv
module srot_decode #(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  oh
);
  always_comb begin
    oh = '0;
    for (int i = 0; i < W; i++) begin
      if (amt == AW'(i)) oh[i] = 1'b1;
    end
  end
endmodule

// File: rtl/srot_core.sv
module srot_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  input  logic         c,
  input  logic [2:0]   mode,
  input  logic         dir,
  input  logic [W-1:0] oh,
  output logic [W-1:0] res,
  output logic         cout
);
  import srot_pkg::*;

  logic [W-1:0] cand_res [W];
  logic         cand_cy  [W];
  logic         fill_bit;
  logic         is_rot;
  logic         is_rcy;
  logic         sel_ok;
  logic [W:0]   loop_v;

  assign fill_bit = fill_for(mode, dir, d[W-1]);
  assign is_rot   = (mode == SR_ROT);
  assign is_rcy   = (mode == SR_RCY);
  assign sel_ok   = $onehot(oh) && mode_known(mode);
  assign loop_v   = {c, d};

  generate
    for (genvar k = 0; k < W; k++) begin : g_dist
      if (k == 0) begin : g_zero
        assign cand_res[k] = d;
        assign cand_cy[k]  = c;
      end else begin : g_move
        localparam logic [W-1:0] LOW_M  = W'((1 << k) - 1);
        localparam logic [W-1:0] HIGH_M = ~({W{1'b1}} >> k);
        logic [W:0] t;
        always_comb begin
          t = '0;
          if (dir == DIR_LEFT) begin
            if (is_rcy) begin
              t = (loop_v << k) | (loop_v >> (W + 1 - k));
              cand_res[k] = t[W-1:0];
              cand_cy[k]  = t[W];
            end else if (is_rot) begin
              cand_res[k] = (d << k) | (d >> (W - k));
              cand_cy[k]  = d[W-k];
            end else begin
              cand_res[k] = (d << k) | (fill_bit ? LOW_M : '0);
              cand_cy[k]  = d[W-k];
            end
          end else begin
            if (is_rcy) begin
              t = (loop_v >> k) | (loop_v << (W + 1 - k));
              cand_res[k] = t[W-1:0];
              cand_cy[k]  = t[W];
            end else if (is_rot) begin
              cand_res[k] = (d >> k) | (d << (W - k));
              cand_cy[k]  = d[k-1];
            end else begin
              cand_res[k] = (d >> k) | (fill_bit ? HIGH_M : '0);
              cand_cy[k]  = d[k-1];
            end
          end
        end
      end
    end
  endgenerate

  // A malformed select or reserved mode falls back to the distance-0 path.
  always_comb begin
    res  = d;
    cout = c;
    if (sel_ok) begin
      for (int k = 0; k < W; k++) begin
        if (oh[k]) begin
          res  = cand_res[k];
          cout = cand_cy[k];
        end
      end
    end
  end
endmodule

// File: rtl/srot_unit.sv
module srot_unit #(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          dir,
  input  logic [2:0]    mode,
  output logic [W-1:0]  q,
  output logic          cy
);
  localparam int HALF = W / 2;

  logic [W-1:0] amt_oh;
  logic [W-1:0] nxt_res;
  logic         nxt_cy;

  srot_decode #(.W(W), .AW(AW)) u_dec (
    .amt (amt),
    .oh  (amt_oh)
  );

  srot_core #(.W(W)) u_core (
    .d    (din),
    .c    (cy),
    .mode (mode),
    .dir  (dir),
    .oh   (amt_oh),
    .res  (nxt_res),
    .cout (nxt_cy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= '0;
      cy <= 1'b0;
    end else if (en) begin
      q  <= nxt_res;
      cy <= nxt_cy;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (q == '0 && !cy));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(q) && $stable(cy)));

  p_onehot_sel_r3: assert property (@(posedge clk) disable iff (rst) $onehot(amt_oh));

  p_zero_amt_r3: assert property (@(posedge clk) disable iff (rst)
    (en && amt == '0) |=> (q == $past(din) && cy == $past(cy)));

  p_sign_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 3'd3 && dir && amt != '0) |=> (q[W-1] == $past(din[W-1])));

  p_nibble_swap_r9: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 3'd0 && amt == AW'(HALF))
      |=> (q == {$past(din[HALF-1:0]), $past(din[W-1:HALF])}));

  p_reserved_r11: assert property (@(posedge clk) disable iff (rst)
    (en && mode > 3'd4) |=> (q == $past(din) && cy == $past(cy)));
endmodule

// File: tb/tb_srot_unit.sv
`timescale 1ns/1ps
module tb_srot_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] din = '0;
  logic [2:0] amt = '0;
  logic       dir = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] q;
  logic       cy;

  int n_checks = 0;
  int n_fail   = 0;
  logic exp_c  = 1'b0;
  bit   done   = 0;

  always #2.5 clk = ~clk;

  srot_unit dut (
    .clk(clk), .rst(rst), .en(en), .din(din), .amt(amt),
    .dir(dir), .mode(mode), .q(q), .cy(cy)
  );

  // One position at a time, repeated k times.
  function automatic logic [8:0] model(input logic [7:0] d, input logic c,
                                       input logic [2:0] m, input logic dr, input int k);
    logic o, f;
    if (m > 3'd4 || k == 0) return {c, d};
    for (int i = 0; i < k; i++) begin
      if (!dr) begin
        o = d[7];
        case (m)
          3'd0: f = o;  3'd1: f = 1'b0;  3'd2: f = 1'b1;
          3'd3: f = 1'b0;  default: f = c;
        endcase
        d = {d[6:0], f};
      end else begin
        o = d[0];
        case (m)
          3'd0: f = o;  3'd1: f = 1'b0;  3'd2: f = 1'b1;
          3'd3: f = d[7];  default: f = c;
        endcase
        d = {f, d[7:1]};
      end
      c = o;
    end
    return {c, d};
  endfunction

  function automatic string tag_of(input logic [2:0] m, input int k);
    if (m > 3'd4) return "R11";
    if (k == 0)   return "R3";
    case (m)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got cy,q=%b_%h expected %b_%h", req, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic run_op(input logic [7:0] d, input int k, input logic dr,
                        input logic [2:0] m, input string req);
    logic [8:0] e;
    @(negedge clk);
    din = d; amt = 3'(k); dir = dr; mode = m; en = 1'b1;
    e = model(d, exp_c, m, dr, k);
    @(negedge clk);
    en = 1'b0;
    check(req, {cy, q}, e);
    if (k != 0 && m <= 3'd3 && cy !== e[8]) $display("  R10 carry mismatch above");
    exp_c = e[8];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] vals [12] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A,
                              8'h3C, 8'hC3, 8'h7E, 8'h81, 8'h96, 8'h69};
    logic [7:0] q_hold;
    logic       c_hold;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {cy, q}, 9'h000);
    rst = 1'b0;

    // R4 and R10: load a known carry with a left rotate of 0x80 by 1 -> q=01, cy=1
    run_op(8'h80, 1, 1'b0, 3'd0, "R4");

    // R12: nothing reaches q before the capturing edge
    @(negedge clk);
    din = 8'h0F; amt = 3'd4; dir = 1'b0; mode = 3'd0; en = 1'b1;
    #1;
    check("R12", {cy, q}, {1'b1, 8'h01});
    @(negedge clk);
    en = 1'b0;
    // R9: nibble swap of 0x0F is 0xF0, last wrapped bit is din[4]=0
    check("R9", {cy, q}, {1'b0, 8'hF0});
    exp_c = 1'b0;

    // R2: enable low holds result and carry
    q_hold = q; c_hold = cy;
    @(negedge clk);
    din = 8'hAA; amt = 3'd3; mode = 3'd2; en = 1'b0;
    repeat (2) @(negedge clk);
    check("R2", {cy, q}, {c_hold, q_hold});

    // Sweep: every mode, direction and amount over the data set (R3..R11)
    for (int m = 0; m < 8; m++)
      for (int dr = 0; dr < 2; dr++)
        for (int k = 0; k < 8; k++)
          for (int v = 0; v < 12; v++)
            run_op(vals[v], k, 1'(dr), 3'(m), tag_of(3'(m), k));

    // R8: carry loop with cy=1 rotated right by 7 from 0x00
    run_op(8'hFF, 1, 1'b0, 3'd1, "R10");
    run_op(8'h00, 7, 1'b1, 3'd4, "R8");

    // R1: reset mid-run clears again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", {cy, q}, 9'h000);

    finish_run();
  end
endmodule